// File: doc/BRIEF.md
# Host Controller Interrupt Register Unit

This block keeps the interrupt status word and the interrupt enable mask of a USB host controller and turns them into a single level-sensitive interrupt request. Event logic elsewhere in the controller raises one-cycle pulses for eight conditions. Each pulse latches a sticky status bit: scheduling overrun, done-list writeback, start of frame, resume detected, unrecoverable error, frame counter wrap, root hub change and ownership change. Software reads the latched bits and clears them by writing ones.

Software never writes the enable mask directly. It has one alias that adds bits to the mask and another alias that removes them, and both aliases read back the same mask. The top bit of the mask is a global gate. The request line is high only when that gate is open and at least one latched status bit is also enabled.

The register port is a simple 32-bit word port with a byte address. Reads return their data on the cycle after the read strobe. Accesses whose address is not word aligned have no effect on any register, and a read of such an address returns all ones.

Top module: `hc_irq_regs`

## Requirements
- R1: After reset the status word reads 0, both enable aliases read 0x80000000, and `irqLevel` is low.
- R2: An event pulse on `evtPulse[i]` sets status bit i for i = 0..6 and status bit 30 for i = 7. Several pulses in one cycle all set their bits. Set bits stay set while no clear arrives.
- R3: A write to the status word (byte offset 0x0) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: When an event pulse and a status clear hit the same bit in the same cycle, that bit ends up set.
- R5: A write to the enable-set alias (offset 0x4) ORs the written value into the mask.
- R6: A write to the enable-clear alias (offset 0x8) removes every bit written as 1 from the mask.
- R7: A read of offset 0x4 or offset 0x8 returns the current mask. A read of offset 0x0 returns the status word. The data appears on `busRdData` the cycle after `busRdEn` and holds until the next read.
- R8: `irqLevel` is high exactly when mask bit 31 is set and the AND of status and mask is non-zero. It follows the registers in the same cycle they change.
- R9: A write to an address with a non-zero value in bits [1:0] changes nothing. A read of such an address returns 0xFFFFFFFF.
- R10: Only bits 0..6 and 30 of the status word exist, and only those bits plus bit 31 of the mask exist. All other bits read 0. An aligned address other than 0x0, 0x4 or 0x8 reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte address of the access |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, registered |
| evtPulse | input | 8 | One-cycle event pulses; index 7 is ownership change |
| irqLevel | output | 1 | Level interrupt request |

## Verification
Register updates from writes and events land on the clock edge after the inputs are driven. `irqLevel` is combinational from those registers, so it is due in that same cycle after the edge. Read data is due one edge after `busRdEn`. The bench drives inputs on the falling edge and advances a behavioural model at the following rising edge. It compares both outputs on the next falling edge, every cycle, so each result is checked exactly in the cycle it becomes due.

// File: rtl/hc_irq_pkg.sv
package hc_irq_pkg;

  localparam int REG_W      = 32;
  localparam int NUM_EVT    = 8;
  localparam int MASTER_BIT = REG_W - 1;
  localparam int OWNER_BIT  = REG_W - 2;

  typedef enum logic [1:0] {
    RD_STATUS = 2'd0,
    RD_MASK   = 2'd1,
    RD_ONES   = 2'd2,
    RD_ZERO   = 2'd3
  } rdSrcE;

  typedef struct packed {
    logic  stsClr;
    logic  maskSet;
    logic  maskClr;
    logic  rdEn;
    rdSrcE rdSrc;
  } regStrobeT;

  // Event index to status bit: the last event sits just below the gate bit.
  function automatic int evtBitPos(input int idx);
    return (idx == NUM_EVT - 1) ? OWNER_BIT : idx;
  endfunction

endpackage

// File: rtl/hc_irq_ctrl.sv
module hc_irq_ctrl
  import hc_irq_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int STS_OFF = 0,
  parameter int ENS_OFF = 4,
  parameter int ENC_OFF = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output regStrobeT         strobe
);

  localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(STS_OFF);
  localparam logic [ADDR_W-1:0] ENS_A = ADDR_W'(ENS_OFF);
  localparam logic [ADDR_W-1:0] ENC_A = ADDR_W'(ENC_OFF);

  logic misAligned;
  logic hitSts;
  logic hitEns;
  logic hitEnc;
  logic wrOk;

  assign misAligned = |busAddr[1:0];
  assign hitSts     = (busAddr == STS_A);
  assign hitEns     = (busAddr == ENS_A);
  assign hitEnc     = (busAddr == ENC_A);
  assign wrOk       = busWrEn && !misAligned;

  always_comb begin
    strobe.stsClr  = wrOk && hitSts;
    strobe.maskSet = wrOk && hitEns;
    strobe.maskClr = wrOk && hitEnc;
    strobe.rdEn    = busRdEn;
    if (misAligned)            strobe.rdSrc = RD_ONES;
    else if (hitSts)           strobe.rdSrc = RD_STATUS;
    else if (hitEns || hitEnc) strobe.rdSrc = RD_MASK;
    else                       strobe.rdSrc = RD_ZERO;
  end

  // R9: a misaligned write never reaches a register strobe
  a_r9_no_misaligned_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && misAligned) |-> !(strobe.stsClr || strobe.maskSet || strobe.maskClr));

  // At most one register is written per cycle
  a_r10_one_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.stsClr, strobe.maskSet, strobe.maskClr}));

endmodule

// File: rtl/hc_irq_datapath.sv
module hc_irq_datapath
  import hc_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  regStrobeT          strobe,
  input  logic [REG_W-1:0]   wrData,
  input  logic [NUM_EVT-1:0] evtPulse,
  output logic [REG_W-1:0]   rdData,
  output logic               irqLevel
);

  logic [REG_W-1:0] statusQ;
  logic [REG_W-1:0] maskQ;
  logic [REG_W-1:0] rdDataQ;
  logic [REG_W-1:0] evtVec;
  logic [REG_W-1:0] stsBits;
  logic [REG_W-1:0] maskBits;
  logic [REG_W-1:0] statusD;
  logic [REG_W-1:0] maskD;

  // Scatter the event pulses onto their status positions
  generate
    for (genvar gi = 0; gi < REG_W; gi++) begin : g_bitmap
      always_comb begin
        evtVec[gi]  = 1'b0;
        stsBits[gi] = 1'b0;
        for (int e = 0; e < NUM_EVT; e++) begin
          if (evtBitPos(e) == gi) begin
            evtVec[gi]  = evtPulse[e];
            stsBits[gi] = 1'b1;
          end
        end
      end
    end
  endgenerate

  assign maskBits = stsBits | (REG_W'(1) << MASTER_BIT);

  always_comb begin
    statusD = statusQ;
    if (strobe.stsClr) statusD = statusD & ~wrData;
    statusD = statusD | evtVec;

    maskD = maskQ;
    if (strobe.maskSet) maskD = maskD | (wrData & maskBits);
    if (strobe.maskClr) maskD = maskD & ~wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      maskQ   <= REG_W'(1) << MASTER_BIT;
      rdDataQ <= '0;
    end else begin
      statusQ <= statusD & stsBits;
      maskQ   <= maskD;
      if (strobe.rdEn) begin
        unique case (strobe.rdSrc)
          RD_STATUS: rdDataQ <= statusQ;
          RD_MASK:   rdDataQ <= maskQ;
          RD_ONES:   rdDataQ <= '1;
          default:   rdDataQ <= '0;
        endcase
      end
    end
  end

  assign rdData   = rdDataQ;
  assign irqLevel = maskQ[MASTER_BIT] && |(statusQ & maskQ);

  // R2: every pulsed event is latched on the next cycle
  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rstN)
    (|evtVec) |=> ((statusQ & $past(evtVec)) == $past(evtVec)));

  // R2: latched bits are sticky when nothing clears them
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.stsClr |=> ((statusQ & $past(statusQ)) == $past(statusQ)));

  // R3: cleared bits drop when no event hits them
  a_r3_clear: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stsClr && ((evtVec & wrData) == '0)) |=> ((statusQ & $past(wrData)) == '0));

  // R4: an event beats a same-cycle clear
  a_r4_event_wins: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stsClr && |(evtVec & wrData)) |=> |(statusQ & $past(evtVec & wrData)));

  // R5: set alias adds the implemented written bits
  a_r5_mask_set: assert property (@(posedge clk) disable iff (!rstN)
    strobe.maskSet |=> ((maskQ & $past(wrData & maskBits)) == $past(wrData & maskBits)));

  // R6: clear alias removes the written bits
  a_r6_mask_clear: assert property (@(posedge clk) disable iff (!rstN)
    strobe.maskClr |=> ((maskQ & $past(wrData)) == '0));

  // R10: unimplemented bits never appear
  a_r10_no_phantom_bits: assert property (@(posedge clk) disable iff (!rstN)
    ((statusQ & ~stsBits) == '0) && ((maskQ & ~maskBits) == '0));

endmodule

// File: rtl/hc_irq_regs.sv
module hc_irq_regs
  import hc_irq_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int STS_OFF = 0,
  parameter int ENS_OFF = 4,
  parameter int ENC_OFF = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic               busRdEn,
  input  logic [REG_W-1:0]   busWrData,
  output logic [REG_W-1:0]   busRdData,
  input  logic [NUM_EVT-1:0] evtPulse,
  output logic               irqLevel
);

  regStrobeT strobe;

  hc_irq_ctrl #(
    .ADDR_W (ADDR_W),
    .STS_OFF(STS_OFF),
    .ENS_OFF(ENS_OFF),
    .ENC_OFF(ENC_OFF)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .busAddr(busAddr),
    .busWrEn(busWrEn),
    .busRdEn(busRdEn),
    .strobe (strobe)
  );

  hc_irq_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrData  (busWrData),
    .evtPulse(evtPulse),
    .rdData  (busRdData),
    .irqLevel(irqLevel)
  );

  // R9: a misaligned read returns all ones on the next cycle
  a_r9_misaligned_read: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && (busAddr[1:0] != 2'b00)) |=> (busRdData == '1));

  // R7: read data holds between reads
  a_r7_rd_hold: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |=> $stable(busRdData));

endmodule

// File: tb/hc_irq_regs_test.sv
module hc_irq_regs_test;

  localparam int AW = 8;

  logic        clk = 1'b0;
  logic        rstN;
  logic [AW-1:0] busAddr;
  logic        busWrEn;
  logic        busRdEn;
  logic [31:0] busWrData;
  logic [31:0] busRdData;
  logic [7:0]  evtPulse;
  logic        irqLevel;

  int vecCnt  = 0;
  int failCnt = 0;
  bit done    = 0;

  // reference model state
  logic [31:0] mStatus;
  logic [31:0] mMask;
  logic [31:0] mRd;

  localparam logic [31:0] STS_IMPL  = 32'h4000_007F;
  localparam logic [31:0] MASK_IMPL = 32'hC000_007F;

  always #5 clk = ~clk;

  hc_irq_regs #(.ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .evtPulse(evtPulse), .irqLevel(irqLevel)
  );

  function automatic logic [31:0] evtToBits(input logic [7:0] e);
    logic [31:0] v = '0;
    for (int i = 0; i < 7; i++) v[i] = e[i];
    v[30] = e[7];
    return v;
  endfunction

  task automatic compare(input string tag);
    logic expIrq;
    expIrq = mMask[31] && ((mStatus & mMask) != 0);
    vecCnt++;
    if (irqLevel !== expIrq) begin
      failCnt++;
      $display("FAIL %s irqLevel actual=%b expected=%b", tag, irqLevel, expIrq);
    end
    vecCnt++;
    if (busRdData !== mRd) begin
      failCnt++;
      $display("FAIL %s busRdData actual=%h expected=%h", tag, busRdData, mRd);
    end
  endtask

  // one clock: inputs already driven at negedge; model advances at posedge
  task automatic step(input string tag);
    logic [31:0] oldSts;
    logic [31:0] oldMask;
    @(posedge clk);
    oldSts  = mStatus;
    oldMask = mMask;
    if (busRdEn) begin
      if (busAddr[1:0] != 0)              mRd = 32'hFFFF_FFFF;
      else if (busAddr == 8'h0)           mRd = oldSts;
      else if (busAddr == 8'h4 || busAddr == 8'h8) mRd = oldMask;
      else                                mRd = 32'h0;
    end
    if (busWrEn && busAddr[1:0] == 0) begin
      if (busAddr == 8'h0) mStatus = mStatus & ~busWrData;
      if (busAddr == 8'h4) mMask   = mMask | (busWrData & MASK_IMPL);
      if (busAddr == 8'h8) mMask   = mMask & ~busWrData;
    end
    mStatus = (mStatus | evtToBits(evtPulse)) & STS_IMPL;
    @(negedge clk);
    compare(tag);
    busWrEn  = 1'b0;
    busRdEn  = 1'b0;
    evtPulse = '0;
  endtask

  task automatic doWrite(input logic [AW-1:0] a, input logic [31:0] d,
                         input logic [7:0] e, input string tag);
    busAddr = a; busWrData = d; busWrEn = 1'b1; evtPulse = e;
    step(tag);
  endtask

  task automatic doRead(input logic [AW-1:0] a, input string tag);
    busAddr = a; busRdEn = 1'b1;
    step(tag);
  endtask

  task automatic doEvt(input logic [7:0] e, input string tag);
    evtPulse = e;
    step(tag);
  endtask

  initial begin
    rstN = 1'b0; busAddr = '0; busWrEn = 0; busRdEn = 0; busWrData = '0; evtPulse = '0;
    mStatus = '0; mMask = 32'h8000_0000; mRd = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    compare("R1");
    doRead(8'h0, "R1");
    doRead(8'h4, "R1");
    doRead(8'h8, "R1");

    doEvt(8'h04, "R2");                 // start of frame only
    doRead(8'h0, "R2");
    doWrite(8'h4, 32'h0000_0004, 8'h00, "R5");  // enable bit 2: irq rises
    doRead(8'h4, "R5");
    doEvt(8'h91, "R2");                 // bits 0, 4, 30 at once
    doEvt(8'h00, "R2");                 // sticky
    doRead(8'h0, "R2");
    doWrite(8'h0, 32'h0000_0004, 8'h00, "R3");
    doRead(8'h0, "R3");
    doWrite(8'h0, 32'h0000_0000, 8'h00, "R3");  // zeros change nothing
    doRead(8'h0, "R3");

    doWrite(8'h4, 32'hFFFF_FFFF, 8'h00, "R10");
    doRead(8'h8, "R7");
    doRead(8'h4, "R7");
    doWrite(8'h8, 32'h8000_0000, 8'h00, "R8");  // close gate: irq low
    doRead(8'h8, "R6");
    doWrite(8'h4, 32'h8000_0000, 8'h00, "R8");  // reopen gate

    doWrite(8'h0, 32'h0000_0002, 8'h02, "R4");  // event and clear on bit 1
    doRead(8'h0, "R4");
    doWrite(8'h0, 32'hFFFF_FFFF, 8'h00, "R3");
    doRead(8'h0, "R8");

    doEvt(8'h20, "R2");
    doWrite(8'h1, 32'hFFFF_FFFF, 8'h00, "R9");  // misaligned: ignored
    doWrite(8'h6, 32'hFFFF_FFFF, 8'h00, "R9");
    doRead(8'h0, "R9");
    doRead(8'h4, "R9");
    doRead(8'h6, "R9");
    doRead(8'h3, "R9");

    doWrite(8'h10, 32'hFFFF_FFFF, 8'h00, "R10");
    doRead(8'h10, "R10");
    doRead(8'h0, "R10");
    doWrite(8'h8, 32'h0000_0020, 8'h00, "R6");
    doRead(8'h8, "R6");
    doEvt(8'hFF, "R2");
    doRead(8'h0, "R2");
    doRead(8'h14, "R10");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
      $finish;
    end
  end

endmodule